// File: doc/BRIEF.md
# Timer Event Linkage Glue

This block sits between a two-unit timer (four channels per unit, named A to D) and the chip's event router and DMA request lines. On the inbound side, each unit receives one routed event line. The unit's operating mode decides what that event does. In input-capture mode it fires a channel D capture strobe and sets the channel D status flag. In a pulse-output mode it latches a forced cutoff of the pulse outputs, which stays in place until software releases it.

On the outbound side, the block forwards the per-channel capture and compare-match strobes that the timer core produces. Channels A and B of each unit go both to the event router and to the DMA. Channels C and D go to the DMA only. The last unit's counter underflow goes to the event router only, and only in complementary PWM mode. All outbound pulses are registered and are one clock wide.

Top module: `tev_link`

## Requirements
- R1: For unit u, a rising edge on `evt_in[u]` produces exactly one single-cycle `capd_strobe[u]` pulse when that unit's mode field is 0 (input capture) and `cap_en[u]` is 1. The pulse appears on the third rising clock edge that samples the input high (two synchroniser stages, then one output register).
- R2: `capd_strobe[u]` sets `capd_flag[u]` on the same edge. The flag holds until `flag_clr[u]` is sampled high, and it reads 0 after the next clock.
- R3: No capture strobe and no flag change result from an event when the unit's mode is any value 1 to 7, or when `cap_en[u]` is 0.
- R4: When the unit's mode is one of the pulse-output modes (2 PWM, 3 reset-synchronous PWM, 4 complementary PWM, 5 PWM3) and `cut_en[u]` is 1, an event sets `cutoff[u]` with the same latency as R1.
- R5: An event leaves `cutoff[u]` at 0 in mode 0 (input capture), mode 1 (output compare), modes 6 and 7, or when `cut_en[u]` is 0.
- R6: `cutoff[u]` is a one-shot latch. It stays at 1 after the event has gone, and it clears on the clock after `cut_clr[u]` is sampled high.
- R7: An event held high for several cycles yields a single capture strobe. The units act independently, and simultaneous events on both units strobe both.
- R8: `ch_strobe` bit 4u+c (c = 0 for A, 1 for B) appears one clock later both on `evr_out` bit 2u+c and on `dma_out` bit 4u+c.
- R9: `ch_strobe` bit 4u+c for c = 2 (C) or c = 3 (D) appears one clock later on `dma_out` bit 4u+c only. No `evr_out` bit responds to it.
- R10: `udf_strobe` appears one clock later on `evr_out` bit 4 only when unit 1's mode is 4 (complementary PWM). It never reaches `dma_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_mode | input | 6 | Mode field per unit, unit u in bits 3u+2:3u |
| cap_en | input | 2 | Event-capture enable per unit |
| cut_en | input | 2 | Event-cutoff enable per unit |
| evt_in | input | 2 | Routed event per unit (asynchronous) |
| flag_clr | input | 2 | Write-one-to-clear for the channel D flags |
| cut_clr | input | 2 | Write-one-to-clear for the cutoff latches |
| ch_strobe | input | 8 | Capture/match strobes, bit 4u+c |
| udf_strobe | input | 1 | Unit 1 counter underflow strobe |
| capd_strobe | output | 2 | Event-triggered channel D capture strobe |
| capd_flag | output | 2 | Channel D capture/match status flag |
| cutoff | output | 2 | Latched forced cutoff of pulse outputs |
| evr_out | output | 5 | Event router pulses: bit 2u+c for A/B, bit 4 for underflow |
| dma_out | output | 8 | DMA request pulses, bit 4u+c |

## Verification
The bench walks every mode value against both enables, so it exposes a design that confuses output-compare mode with a pulse mode, or that cuts off in capture mode. It holds an event high for several cycles, which a design without an edge detector would answer with a burst of captures. It checks that the cutoff latch survives the end of the event until the clear arrives, which catches a level-following cutoff. It also drives lone C/D strobes and underflows in non-complementary modes, which would expose a routing that leaks them onto the event router or the DMA.

// File: rtl/tev_pkg.sv
package tev_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        TM_CAPTURE = 3'd0,
        TM_COMPARE = 3'd1,
        TM_PWM     = 3'd2,
        TM_RSPWM   = 3'd3,
        TM_CPWM    = 3'd4,
        TM_PWM3    = 3'd5
    } tm_mode_e;

    // Actions an incoming event may request for one unit
    typedef struct packed {
        logic cap;
        logic cut;
    } evt_act_t;

    function automatic logic is_capture_mode(input logic [MODE_W-1:0] m);
        return m == TM_CAPTURE;
    endfunction

    function automatic logic is_pulse_mode(input logic [MODE_W-1:0] m);
        return (m == TM_PWM) || (m == TM_RSPWM) || (m == TM_CPWM) || (m == TM_PWM3);
    endfunction

endpackage

// File: rtl/tev_sync_edge.sv
module tev_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], din};
            prev <= sh[STAGES-1];
        end
    end

    assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/tev_unit_ctl.sv
module tev_unit_ctl
    import tev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              cap_en,
    input  logic              cut_en,
    input  logic              evt_rise,
    input  logic              flag_clr,
    input  logic              cut_clr,
    output logic              capd_strobe,
    output logic              capd_flag,
    output logic              cutoff
);
    evt_act_t act;

    always_comb begin
        act.cap = evt_rise & is_capture_mode(mode) & cap_en;
        act.cut = evt_rise & is_pulse_mode(mode) & cut_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            capd_strobe <= 1'b0;
            capd_flag   <= 1'b0;
            cutoff      <= 1'b0;
        end else begin
            capd_strobe <= act.cap;
            if (act.cap)       capd_flag <= 1'b1;
            else if (flag_clr) capd_flag <= 1'b0;
            if (act.cut)       cutoff <= 1'b1;
            else if (cut_clr)  cutoff <= 1'b0;
        end
    end
endmodule

// File: rtl/tev_route.sv
module tev_route
    import tev_pkg::*;
#(
    parameter int NUM_UNITS   = 2,
    parameter int CH_PER_UNIT = 4,
    parameter int ROUTED_CH   = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_UNITS*CH_PER_UNIT-1:0] ch_strobe,
    input  logic                             udf_strobe,
    input  logic [MODE_W-1:0]                udf_mode,
    output logic [NUM_UNITS*ROUTED_CH:0]     evr_out,
    output logic [NUM_UNITS*CH_PER_UNIT-1:0] dma_out
);
    localparam int EVR_W = NUM_UNITS*ROUTED_CH + 1;

    logic [EVR_W-1:0] evr_d;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        for (genvar c = 0; c < ROUTED_CH; c++) begin : g_ch
            assign evr_d[u*ROUTED_CH + c] = ch_strobe[u*CH_PER_UNIT + c];
        end
    end
    assign evr_d[EVR_W-1] = udf_strobe & (udf_mode == TM_CPWM);

    always_ff @(posedge clk) begin
        if (rst) begin
            evr_out <= '0;
            dma_out <= '0;
        end else begin
            evr_out <= evr_d;
            dma_out <= ch_strobe;
        end
    end
endmodule

// File: rtl/tev_link.sv
module tev_link
    import tev_pkg::*;
#(
    parameter int NUM_UNITS   = 2,
    parameter int CH_PER_UNIT = 4,
    parameter int ROUTED_CH   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_UNITS*MODE_W-1:0]      unit_mode,
    input  logic [NUM_UNITS-1:0]             cap_en,
    input  logic [NUM_UNITS-1:0]             cut_en,
    input  logic [NUM_UNITS-1:0]             evt_in,
    input  logic [NUM_UNITS-1:0]             flag_clr,
    input  logic [NUM_UNITS-1:0]             cut_clr,
    input  logic [NUM_UNITS*CH_PER_UNIT-1:0] ch_strobe,
    input  logic                             udf_strobe,
    output logic [NUM_UNITS-1:0]             capd_strobe,
    output logic [NUM_UNITS-1:0]             capd_flag,
    output logic [NUM_UNITS-1:0]             cutoff,
    output logic [NUM_UNITS*ROUTED_CH:0]     evr_out,
    output logic [NUM_UNITS*CH_PER_UNIT-1:0] dma_out
);
    localparam int LAST = NUM_UNITS - 1;

    logic [NUM_UNITS-1:0] evt_rise;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        tev_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (evt_in[u]),
            .rise (evt_rise[u])
        );

        tev_unit_ctl u_ctl (
            .clk         (clk),
            .rst         (rst),
            .mode        (unit_mode[u*MODE_W +: MODE_W]),
            .cap_en      (cap_en[u]),
            .cut_en      (cut_en[u]),
            .evt_rise    (evt_rise[u]),
            .flag_clr    (flag_clr[u]),
            .cut_clr     (cut_clr[u]),
            .capd_strobe (capd_strobe[u]),
            .capd_flag   (capd_flag[u]),
            .cutoff      (cutoff[u])
        );
    end

    tev_route #(
        .NUM_UNITS   (NUM_UNITS),
        .CH_PER_UNIT (CH_PER_UNIT),
        .ROUTED_CH   (ROUTED_CH)
    ) u_route (
        .clk        (clk),
        .rst        (rst),
        .ch_strobe  (ch_strobe),
        .udf_strobe (udf_strobe),
        .udf_mode   (unit_mode[LAST*MODE_W +: MODE_W]),
        .evr_out    (evr_out),
        .dma_out    (dma_out)
    );
endmodule

// File: rtl/tev_link_chk.sv
module tev_link_chk
    import tev_pkg::*;
#(
    parameter int NUM_UNITS   = 2,
    parameter int CH_PER_UNIT = 4,
    parameter int ROUTED_CH   = 2
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_UNITS*MODE_W-1:0]      unit_mode,
    input logic [NUM_UNITS-1:0]             cap_en,
    input logic [NUM_UNITS-1:0]             cut_en,
    input logic [NUM_UNITS-1:0]             cut_clr,
    input logic [NUM_UNITS-1:0]             capd_strobe,
    input logic [NUM_UNITS-1:0]             capd_flag,
    input logic [NUM_UNITS-1:0]             cutoff,
    input logic [NUM_UNITS*ROUTED_CH:0]     evr_out,
    input logic [NUM_UNITS*CH_PER_UNIT-1:0] dma_out
);
    localparam int LAST = NUM_UNITS - 1;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        // R1
        cap_gate_chk: assert property (@(posedge clk) disable iff (rst)
            capd_strobe[u] |-> $past(is_capture_mode(unit_mode[u*MODE_W +: MODE_W]) && cap_en[u]));

        // R1
        strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
            capd_strobe[u] |=> !capd_strobe[u]);

        // R2
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            capd_strobe[u] |-> capd_flag[u]);

        // R4
        cut_gate_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(cutoff[u]) |-> $past(is_pulse_mode(unit_mode[u*MODE_W +: MODE_W]) && cut_en[u]));

        // R6
        cut_hold_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(cutoff[u]) && !$past(cut_clr[u])) |-> cutoff[u]);

        for (genvar c = 0; c < ROUTED_CH; c++) begin : g_ch
            // R8
            route_ab_chk: assert property (@(posedge clk) disable iff (rst)
                evr_out[u*ROUTED_CH + c] == dma_out[u*CH_PER_UNIT + c]);
        end
    end

    // R10
    udf_mode_chk: assert property (@(posedge clk) disable iff (rst)
        evr_out[NUM_UNITS*ROUTED_CH] |-> $past(unit_mode[LAST*MODE_W +: MODE_W] == TM_CPWM));
endmodule

bind tev_link tev_link_chk #(
    .NUM_UNITS   (NUM_UNITS),
    .CH_PER_UNIT (CH_PER_UNIT),
    .ROUTED_CH   (ROUTED_CH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .unit_mode   (unit_mode),
    .cap_en      (cap_en),
    .cut_en      (cut_en),
    .cut_clr     (cut_clr),
    .capd_strobe (capd_strobe),
    .capd_flag   (capd_flag),
    .cutoff      (cutoff),
    .evr_out     (evr_out),
    .dma_out     (dma_out)
);

// File: tb/tev_link_bench.sv
module tev_link_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] unit_mode = '0;
    logic [1:0] cap_en = '0, cut_en = '0, evt_in = '0, flag_clr = '0, cut_clr = '0;
    logic [7:0] ch_strobe = '0;
    logic       udf_strobe = 1'b0;
    logic [1:0] capd_strobe, capd_flag, cutoff;
    logic [4:0] evr_out;
    logic [7:0] dma_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tev_link u_tev_link (
        .clk(clk), .rst(rst), .unit_mode(unit_mode), .cap_en(cap_en), .cut_en(cut_en),
        .evt_in(evt_in), .flag_clr(flag_clr), .cut_clr(cut_clr), .ch_strobe(ch_strobe),
        .udf_strobe(udf_strobe), .capd_strobe(capd_strobe), .capd_flag(capd_flag),
        .cutoff(cutoff), .evr_out(evr_out), .dma_out(dma_out)
    );

    // {unit1 mode, ch_strobe, udf, expected evr_out, expected dma_out}
    localparam int NV = 10;
    localparam logic [24:0] VEC [NV] = '{
        {3'd4, 8'h01, 1'b0, 5'b00001, 8'h01},
        {3'd4, 8'h02, 1'b0, 5'b00010, 8'h02},
        {3'd4, 8'h0C, 1'b0, 5'b00000, 8'h0C},
        {3'd4, 8'h10, 1'b0, 5'b00100, 8'h10},
        {3'd4, 8'h20, 1'b0, 5'b01000, 8'h20},
        {3'd4, 8'hC0, 1'b0, 5'b00000, 8'hC0},
        {3'd4, 8'h00, 1'b1, 5'b10000, 8'h00},
        {3'd2, 8'h00, 1'b1, 5'b00000, 8'h00},
        {3'd4, 8'hFF, 1'b1, 5'b11111, 8'hFF},
        {3'd0, 8'h33, 1'b0, 5'b01111, 8'h33}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive an event on the units in mask for width cycles, count strobes per unit
    task automatic fire(input logic [1:0] mask, input int width, output int n0, output int n1);
        n0 = 0;
        n1 = 0;
        for (int i = 0; i < width + 6; i++) begin
            @(negedge clk);
            n0 += int'(capd_strobe[0]);
            n1 += int'(capd_strobe[1]);
            evt_in = (i < width) ? mask : 2'b00;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog req=none actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0, n1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R2 reset flag", 32'(capd_flag), 0);
        chk("R6 reset cutoff", 32'(cutoff), 0);
        chk("R1 reset strobe", 32'(capd_strobe), 0);
        chk("R8 reset evr", 32'(evr_out), 0);
        chk("R9 reset dma", 32'(dma_out), 0);

        // routing table
        for (int k = 0; k < NV; k++) begin
            unit_mode  = {VEC[k][24:22], 3'd0};
            ch_strobe  = VEC[k][21:14];
            udf_strobe = VEC[k][13];
            @(negedge clk);
            ch_strobe  = '0;
            udf_strobe = 1'b0;
            if (VEC[k][13]) begin
                chk("R10 evr", 32'(evr_out), 32'(VEC[k][12:8]));
                chk("R10 dma", 32'(dma_out), 32'(VEC[k][7:0]));
            end else if ((VEC[k][21:14] & 8'hCC) != 0) begin
                chk("R9 evr", 32'(evr_out), 32'(VEC[k][12:8]));
                chk("R9 dma", 32'(dma_out), 32'(VEC[k][7:0]));
            end else begin
                chk("R8 evr", 32'(evr_out), 32'(VEC[k][12:8]));
                chk("R8 dma", 32'(dma_out), 32'(VEC[k][7:0]));
            end
            @(negedge clk);
            chk("R8 pulse width", 32'(evr_out | 5'(dma_out)), 0);
        end

        // R1 exact latency
        unit_mode = 6'b000_000;
        cap_en = 2'b01;
        evt_in = 2'b01;
        @(negedge clk);
        evt_in = 2'b00;
        @(negedge clk);
        chk("R1 not early", 32'(capd_strobe), 0);
        @(negedge clk);
        chk("R1 strobe", 32'(capd_strobe), 32'b01);
        chk("R2 flag set", 32'(capd_flag), 32'b01);
        chk("R5 no cutoff in capture", 32'(cutoff), 0);
        @(negedge clk);
        chk("R1 one cycle", 32'(capd_strobe), 0);

        // R2 hold and clear
        repeat (5) @(negedge clk);
        chk("R2 flag holds", 32'(capd_flag), 32'b01);
        flag_clr = 2'b01;
        @(negedge clk);
        flag_clr = 2'b00;
        chk("R2 flag cleared", 32'(capd_flag), 0);

        // R3 capture ignored in other modes and when disabled
        cap_en = 2'b11;
        for (int m = 1; m < 8; m++) begin
            unit_mode = {3'(m), 3'd0};
            fire(2'b10, 1, n0, n1);
            chk("R3 mode blocks capture", 32'(n1), 0);
            chk("R3 flag untouched", 32'(capd_flag), 0);
        end
        unit_mode = 6'b000_000;
        cap_en = 2'b01;
        fire(2'b10, 1, n0, n1);
        chk("R3 cap_en low", 32'(n1), 0);

        // R4/R6 cutoff in every pulse mode
        cut_en = 2'b11;
        for (int m = 2; m < 6; m++) begin
            unit_mode = {3'd0, 3'(m)};
            fire(2'b01, 1, n0, n1);
            chk("R4 cutoff set", 32'(cutoff), 32'b01);
            chk("R4 no capture strobe", 32'(n0), 0);
            repeat (4) @(negedge clk);
            chk("R6 cutoff latched", 32'(cutoff), 32'b01);
            cut_clr = 2'b01;
            @(negedge clk);
            cut_clr = 2'b00;
            chk("R6 cutoff cleared", 32'(cutoff), 0);
        end

        // R5 cutoff ignored
        cap_en = 2'b00;
        for (int m = 0; m < 8; m++) begin
            if (m >= 2 && m <= 5) continue;
            unit_mode = {3'(m), 3'(m)};
            fire(2'b11, 1, n0, n1);
            chk("R5 mode blocks cutoff", 32'(cutoff), 0);
        end
        unit_mode = {3'd2, 3'd2};
        cut_en = 2'b00;
        fire(2'b11, 1, n0, n1);
        chk("R5 cut_en low", 32'(cutoff), 0);

        // R7 long event and both units at once
        unit_mode = 6'b000_000;
        cap_en = 2'b11;
        fire(2'b01, 5, n0, n1);
        chk("R7 single strobe for held event", 32'(n0), 1);
        chk("R7 other unit idle", 32'(n1), 0);
        fire(2'b11, 1, n0, n1);
        chk("R7 unit0 strobe", 32'(n0), 1);
        chk("R7 unit1 strobe", 32'(n1), 1);
        chk("R2 both flags", 32'(capd_flag), 32'b11);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule